// File: doc/BRIEF.md
# LPC I/O Cycle Splitter

This block sits between a host-side I/O request port and an LPC host cycle engine. A host I/O read or write of 1, 2 or 4 bytes is taken only when every byte it touches lies inside a decode window. The window is given by the inclusive `win_base` and `win_limit` inputs. An accepted access is issued to the cycle engine as a run of single-byte LPC I/O transfers at consecutive addresses. Each transfer uses a request/done handshake.

For reads, the engine returns one byte with each done and says whether a peripheral claimed the cycle. The block assembles the bytes into one little-endian host word. A byte that no peripheral claimed reads as FFh, the value a pulled-up bus would show. Writes to unclaimed addresses complete with no error indication. The host sees a single one-cycle response after the last byte transfer. No new request is taken while a split sequence is running.

Top module: `lpc_io_splitter`

## Requirements
- R1: A request is accepted (`host_req_ready` high) only when its lowest and highest byte addresses both lie within `win_base`..`win_limit` inclusive, with no wrap past the top of the address space. Otherwise it is left unclaimed: ready stays low and no LPC transfer starts.
- R2: `host_req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. An accepted access produces exactly that many LPC byte transfers. Code 3 is never accepted.
- R3: The first transfer uses the host address, and each later transfer uses the previous address plus one.
- R4: On a write, transfer number i (counting from 0) carries bits [8i+7:8i] of `host_req_wdata` on `lpc_wdata`, and `lpc_write` is high.
- R5: Read data is little-endian. The byte from transfer i lands in bits [8i+7:8i] of `host_rsp_rdata`, and bits above the access width read 0.
- R6: A read byte whose done arrives with `lpc_claimed` low is returned as 8'hFF, whatever is on `lpc_rdata`.
- R7: `lpc_req` goes high on the cycle after acceptance and stays high, with address and data stable, until `lpc_done`. The next transfer's address is presented on the cycle after that done.
- R8: `host_rsp_valid` is high for exactly one cycle, the cycle after the done of the last transfer, with `lpc_req` low. Writes respond too, with `host_rsp_rdata` = 0.
- R9: While a split sequence or its response is in progress, `host_req_ready` is low and any host request is ignored.
- R10: After reset, `lpc_req` and `host_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_base | input | ADDR_W | Lowest decoded I/O address |
| win_limit | input | ADDR_W | Highest decoded I/O address |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Request taken on this edge |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_size | input | 2 | Access size code |
| host_req_addr | input | ADDR_W | Lowest byte address of the access |
| host_req_wdata | input | 32 | Write data, little-endian |
| host_rsp_valid | output | 1 | One-cycle completion |
| host_rsp_rdata | output | 32 | Assembled read data |
| lpc_req | output | 1 | Byte transfer request to the cycle engine |
| lpc_write | output | 1 | Transfer direction |
| lpc_addr | output | ADDR_W | Byte address of the transfer |
| lpc_wdata | output | 8 | Write byte |
| lpc_done | input | 1 | One-cycle transfer completion |
| lpc_claimed | input | 1 | Peripheral claimed the transfer |
| lpc_rdata | input | 8 | Read byte |

## Verification
Each access size is run as both a read and a write, with the engine's done latency varied between 0 and 3 wait cycles. This separates correct request holding from correct byte counting. Reads mix claimed and unclaimed bytes in patterns such as alternating lanes, so a lane-order fault can be told apart from an FFh substitution fault. Rejected requests probe each window edge, a straddle across the limit, a wrap past address FFFFh and the reserved size code. Host requests raised during a running sequence show whether the busy lockout holds.

// File: rtl/lpc_split_pkg.sv
package lpc_split_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } split_state_e;

    localparam logic [7:0] FLOAT_BYTE = 8'hFF;
endpackage

// File: rtl/lpc_window_decode.sv
module lpc_window_decode #(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 2,
    parameter int HOST_BYTES = 4,
    parameter int IDX_W      = $clog2(HOST_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              hit,
    output logic [IDX_W-1:0]  last_idx
);
    localparam int SIZE_CODES = IDX_W + 1;

    logic              size_ok;
    logic [ADDR_W:0]   span_bytes;
    logic [ADDR_W:0]   last_ext;

    always_comb begin
        size_ok    = (int'(size) < SIZE_CODES);
        span_bytes = (ADDR_W+1)'(1) << size;
        last_ext   = {1'b0, addr} + span_bytes - (ADDR_W+1)'(1);
        hit        = size_ok && (addr >= base) && (last_ext <= {1'b0, limit});
        last_idx   = IDX_W'(span_bytes - (ADDR_W+1)'(1));
    end
endmodule

// File: rtl/lpc_lane_merge.sv
module lpc_lane_merge #(
    parameter int HOST_BYTES = 4,
    parameter int IDX_W      = $clog2(HOST_BYTES),
    parameter int DATA_W     = HOST_BYTES * 8
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        byte_in,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < HOST_BYTES; g++) begin : g_lane
        assign merged[8*g +: 8] = (idx == IDX_W'(g)) ? byte_in : acc[8*g +: 8];
    end
endmodule

// File: rtl/lpc_lane_pick.sv
module lpc_lane_pick #(
    parameter int HOST_BYTES = 4,
    parameter int IDX_W      = $clog2(HOST_BYTES),
    parameter int DATA_W     = HOST_BYTES * 8
) (
    input  logic [DATA_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        byte_out
);
    logic [7:0] lanes [HOST_BYTES];

    for (genvar g = 0; g < HOST_BYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_out = lanes[idx];
endmodule

// File: rtl/lpc_io_splitter.sv
module lpc_io_splitter #(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 2,
    parameter int HOST_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       win_base,
    input  logic [ADDR_W-1:0]       win_limit,
    input  logic                    host_req_valid,
    output logic                    host_req_ready,
    input  logic                    host_req_write,
    input  logic [SIZE_W-1:0]       host_req_size,
    input  logic [ADDR_W-1:0]       host_req_addr,
    input  logic [HOST_BYTES*8-1:0] host_req_wdata,
    output logic                    host_rsp_valid,
    output logic [HOST_BYTES*8-1:0] host_rsp_rdata,
    output logic                    lpc_req,
    output logic                    lpc_write,
    output logic [ADDR_W-1:0]       lpc_addr,
    output logic [7:0]              lpc_wdata,
    input  logic                    lpc_done,
    input  logic                    lpc_claimed,
    input  logic [7:0]              lpc_rdata
);
    import lpc_split_pkg::*;

    localparam int DATA_W = HOST_BYTES * 8;
    localparam int IDX_W  = $clog2(HOST_BYTES);

    typedef struct packed {
        split_state_e       state;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic               write;
    } split_regs_t;

    split_regs_t r_q, r_d;

    logic              win_hit;
    logic [IDX_W-1:0]  req_last;
    logic [7:0]        rx_byte;
    logic [DATA_W-1:0] rx_merged;
    logic [7:0]        tx_byte;

    lpc_window_decode #(
        .ADDR_W     (ADDR_W),
        .SIZE_W     (SIZE_W),
        .HOST_BYTES (HOST_BYTES),
        .IDX_W      (IDX_W)
    ) i_decode (
        .addr     (host_req_addr),
        .size     (host_req_size),
        .base     (win_base),
        .limit    (win_limit),
        .hit      (win_hit),
        .last_idx (req_last)
    );

    assign rx_byte = lpc_claimed ? lpc_rdata : FLOAT_BYTE;

    lpc_lane_merge #(
        .HOST_BYTES (HOST_BYTES),
        .IDX_W      (IDX_W),
        .DATA_W     (DATA_W)
    ) i_merge (
        .acc     (r_q.rdata),
        .idx     (r_q.idx),
        .byte_in (rx_byte),
        .merged  (rx_merged)
    );

    lpc_lane_pick #(
        .HOST_BYTES (HOST_BYTES),
        .IDX_W      (IDX_W),
        .DATA_W     (DATA_W)
    ) i_pick (
        .word     (r_q.wdata),
        .idx      (r_q.idx),
        .byte_out (tx_byte)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (host_req_valid && win_hit) begin
                    r_d.state = ST_BUS;
                    r_d.addr  = host_req_addr;
                    r_d.wdata = host_req_wdata;
                    r_d.rdata = '0;
                    r_d.idx   = '0;
                    r_d.last  = req_last;
                    r_d.write = host_req_write;
                end
            end
            ST_BUS: begin
                if (lpc_done) begin
                    if (!r_q.write) begin
                        r_d.rdata = rx_merged;
                    end
                    if (r_q.idx == r_q.last) begin
                        r_d.state = ST_RESP;
                    end else begin
                        r_d.idx  = r_q.idx + IDX_W'(1);
                        r_d.addr = r_q.addr + ADDR_W'(1);
                    end
                end
            end
            ST_RESP: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign host_req_ready = (r_q.state == ST_IDLE) && win_hit;
    assign host_rsp_valid = (r_q.state == ST_RESP);
    assign host_rsp_rdata = r_q.rdata;
    assign lpc_req        = (r_q.state == ST_BUS);
    assign lpc_write      = r_q.write;
    assign lpc_addr       = r_q.addr;
    assign lpc_wdata      = tx_byte;
endmodule

// File: rtl/lpc_io_splitter_chk.sv
module lpc_io_splitter_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] win_base,
    input logic [ADDR_W-1:0] win_limit,
    input logic              host_req_ready,
    input logic              host_rsp_valid,
    input logic              lpc_req,
    input logic [ADDR_W-1:0] lpc_addr,
    input logic [7:0]        lpc_wdata,
    input logic              lpc_done
);
    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpc_req) |-> (lpc_addr >= win_base && lpc_addr <= win_limit)); // R1

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (lpc_req && $past(lpc_req) && $past(lpc_done)) |-> (lpc_addr == $past(lpc_addr) + ADDR_W'(1))); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lpc_req && !lpc_done) |=> (lpc_req && $stable(lpc_addr) && $stable(lpc_wdata))); // R7

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid |=> !host_rsp_valid); // R8

    AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid |-> ($past(lpc_done) && !lpc_req)); // R8

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (lpc_req || host_rsp_valid) |-> !host_req_ready); // R9
endmodule

bind lpc_io_splitter lpc_io_splitter_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .win_base       (win_base),
    .win_limit      (win_limit),
    .host_req_ready (host_req_ready),
    .host_rsp_valid (host_rsp_valid),
    .lpc_req        (lpc_req),
    .lpc_addr       (lpc_addr),
    .lpc_wdata      (lpc_wdata),
    .lpc_done       (lpc_done)
);

// File: tb/test_lpc_io_splitter.sv
module test_lpc_io_splitter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] win_base = 16'h0060;
    logic [15:0] win_limit = 16'h006F;
    logic        host_req_valid = 1'b0;
    logic        host_req_ready;
    logic        host_req_write = 1'b0;
    logic [1:0]  host_req_size = 2'd0;
    logic [15:0] host_req_addr = 16'h0000;
    logic [31:0] host_req_wdata = 32'h0;
    logic        host_rsp_valid;
    logic [31:0] host_rsp_rdata;
    logic        lpc_req;
    logic        lpc_write;
    logic [15:0] lpc_addr;
    logic [7:0]  lpc_wdata;
    logic        lpc_done = 1'b0;
    logic        lpc_claimed = 1'b0;
    logic [7:0]  lpc_rdata = 8'h00;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpc_io_splitter i_lpc_io_splitter (
        .clk, .rst_n, .win_base, .win_limit,
        .host_req_valid, .host_req_ready, .host_req_write, .host_req_size,
        .host_req_addr, .host_req_wdata, .host_rsp_valid, .host_rsp_rdata,
        .lpc_req, .lpc_write, .lpc_addr, .lpc_wdata,
        .lpc_done, .lpc_claimed, .lpc_rdata
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One accepted access; the reference outcome is built from a byte queue.
    task automatic run_access(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                              input logic [31:0] wd, input logic [3:0] claim,
                              input int lat, input bit poke_busy);
        int nbytes = 1 << sz;
        logic [7:0] supplied[$];
        logic [31:0] exp_rd = 32'h0;
        @(negedge clk);
        host_req_valid = 1'b1; host_req_write = wr; host_req_addr = a;
        host_req_size = sz; host_req_wdata = wd;
        #1 chk(host_req_ready == 1'b1, "R1", "ready for in-window access", 32'(host_req_ready), 1);
        @(negedge clk);
        host_req_valid = 1'b0;
        for (int i = 0; i < nbytes; i++) begin
            for (int w = 0; w <= lat; w++) begin
                chk(lpc_req == 1'b1, "R7", "lpc_req held", 32'(lpc_req), 1);
                chk(lpc_addr == a + 16'(i), "R3", "byte address", 32'(lpc_addr), 32'(a + 16'(i)));
                chk(lpc_write == wr, "R4", "direction", 32'(lpc_write), 32'(wr));
                if (wr) chk(lpc_wdata == wd[8*i +: 8], "R4", "write byte", 32'(lpc_wdata), 32'(wd[8*i +: 8]));
                if (poke_busy) begin
                    host_req_valid = (w != lat); host_req_addr = win_base;
                    host_req_size = 2'd0;
                    #1 chk(host_req_ready == 1'b0, "R9", "ready while busy", 32'(host_req_ready), 0);
                end
                if (w == lat) begin
                    lpc_done = 1'b1;
                    lpc_claimed = claim[i];
                    lpc_rdata = 8'h3C ^ 8'(a) ^ 8'(i * 17);
                    supplied.push_back(claim[i] ? lpc_rdata : 8'hFF);
                end
                @(negedge clk);
                lpc_done = 1'b0; lpc_claimed = 1'b0; lpc_rdata = 8'h00;
            end
        end
        if (!wr) begin
            for (int i = 0; i < nbytes; i++) exp_rd[8*i +: 8] = supplied[i];
        end
        chk(host_rsp_valid == 1'b1, "R8", "response after last done", 32'(host_rsp_valid), 1);
        chk(lpc_req == 1'b0, "R2", "no extra byte transfer", 32'(lpc_req), 0);
        chk(host_rsp_rdata == exp_rd, wr ? "R8" : "R5", "response data (R6 FF lanes)", host_rsp_rdata, exp_rd);
        @(negedge clk);
        chk(host_rsp_valid == 1'b0, "R8", "response single cycle", 32'(host_rsp_valid), 0);
        chk(lpc_req == 1'b0, "R9", "idle after response", 32'(lpc_req), 0);
    endtask

    task automatic reject(input logic [15:0] a, input logic [1:0] sz, input string tag);
        @(negedge clk);
        host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = a; host_req_size = sz;
        for (int k = 0; k < 3; k++) begin
            #1 chk(host_req_ready == 1'b0, tag, "out-of-window ready", 32'(host_req_ready), 0);
            chk(lpc_req == 1'b0, tag, "no transfer for unclaimed request", 32'(lpc_req), 0);
            @(negedge clk);
        end
        host_req_valid = 1'b0;
        chk(lpc_req == 1'b0, tag, "no transfer after withdraw", 32'(lpc_req), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lpc_req == 1'b0, "R10", "lpc_req in reset", 32'(lpc_req), 0);
        chk(host_rsp_valid == 1'b0, "R10", "rsp in reset", 32'(host_rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lpc_req == 1'b0, "R10", "lpc_req after reset", 32'(lpc_req), 0);
        chk(host_rsp_valid == 1'b0, "R10", "rsp after reset", 32'(host_rsp_valid), 0);

        run_access(1'b1, 16'h0060, 2'd0, 32'hA1B2C3D4, 4'b1111, 0, 1'b0); // R2 single byte write
        run_access(1'b0, 16'h0064, 2'd1, 32'h0, 4'b1111, 2, 1'b0);        // R5 16-bit read
        run_access(1'b0, 16'h0068, 2'd2, 32'h0, 4'b1010, 1, 1'b0);        // R6 lanes 0,2 unclaimed
        run_access(1'b1, 16'h006C, 2'd2, 32'h11223344, 4'b0000, 3, 1'b0); // R4 write, top edge, unclaimed
        run_access(1'b0, 16'h006F, 2'd0, 32'h0, 4'b0000, 0, 1'b0);        // R6 whole byte FF
        run_access(1'b0, 16'h0062, 2'd2, 32'h0, 4'b0101, 2, 1'b1);        // R9 pokes while busy
        run_access(1'b1, 16'h0066, 2'd1, 32'hDEADBEEF, 4'b0011, 1, 1'b1); // R9 write

        reject(16'h0070, 2'd0, "R1");  // above limit
        reject(16'h005F, 2'd0, "R1");  // below base
        reject(16'h006E, 2'd2, "R1");  // straddles limit
        reject(16'h005F, 2'd1, "R1");  // straddles base
        reject(16'h0060, 2'd3, "R2");  // reserved size code

        win_base = 16'hFFFC; win_limit = 16'hFFFF;
        run_access(1'b0, 16'hFFFC, 2'd2, 32'h0, 4'b1001, 0, 1'b0);        // R3 top of space
        reject(16'hFFFE, 2'd2, "R1");  // wraps past FFFFh

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule